// File: doc/BRIEF.md
# Register Rename Map with Free Pool

This block renames one instruction per cycle for an out-of-order core. Each of the architectural registers maps to one physical register held in a speculative map. When an instruction names a destination, the block takes an unused physical register from a free pool. It returns that register as the new destination tag, together with the physical register the destination mapped to until then (the superseded tag). The two source indices are translated through the same speculative map in the same cycle. All lookup outputs are combinational, and the state changes at the next rising clock edge.

A second, committed map follows the machine state at retirement. When an instruction retires, the commit port writes its new mapping into the committed map, and the superseded register it reported at rename goes back to the pool. A one-cycle recovery pulse discards all speculative work. It copies the committed map into the speculative map and refills the pool with every physical register that the committed map does not reference. When a destination is requested and the pool is empty, the block raises a stall flag and leaves its state untouched.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers NUM_ARCH to NUM_PHYS-1 are free.
- R2: An accepted rename (rn_valid=1, rn_wen=1, no stall, no recovery) allocates the lowest-numbered free physical register. The same lowest free register is always shown on rn_dst_tag, whether or not a rename is requested.
- R3: rn_old_tag shows the speculative mapping of rn_dst as it stands before the edge, which is the register superseded by the rename.
- R4: After an accepted rename, a source naming that destination translates to the newly allocated register.
- R5: Within one cycle, sources are translated before the destination update, so an instruction that reads and writes the same register gets the old mapping.
- R6: A request with rn_valid=0 or rn_wen=0 allocates nothing and leaves the speculative map unchanged.
- R7: When the pool is empty and rn_valid=1 with rn_wen=1, rn_stall is 1 and neither the map nor the pool changes. rn_stall is 0 otherwise.
- R8: A commit (cm_valid=1) returns cm_old_tag to the pool from the next cycle on.
- R9: A commit writes cm_new_tag into the committed map at cm_arch. A recovery pulse copies the committed map, including a commit in the same cycle, into the speculative map.
- R10: On recovery, the pool is rebuilt to hold exactly the physical registers that the restored committed map does not reference.
- R11: Recovery takes priority over a rename in the same cycle: the rename is dropped, and rn_stall is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_valid | input | 1 | Rename request present |
| rn_wen | input | 1 | Request writes a destination |
| rn_src1 | input | AW | First source architectural index |
| rn_src2 | input | AW | Second source architectural index |
| rn_dst | input | AW | Destination architectural index |
| rn_src1_tag | output | PW | Physical tag of first source |
| rn_src2_tag | output | PW | Physical tag of second source |
| rn_dst_tag | output | PW | Newly allocated physical tag |
| rn_old_tag | output | PW | Superseded physical tag of the destination |
| rn_stall | output | 1 | No free physical register for a destination request |
| cm_valid | input | 1 | Commit of a renamed instruction |
| cm_arch | input | AW | Committed destination architectural index |
| cm_new_tag | input | PW | Physical tag the committed instruction wrote |
| cm_old_tag | input | PW | Superseded tag to return to the pool |
| recover | input | 1 | Mispredict recovery pulse |

## Verification
A corrupted speculative map shows up at once on the source tags and the superseded tag, in the first cycle a request names the damaged entry. A wrong pool bit shows up on rn_dst_tag as soon as it becomes the lowest free register, or as a stall that comes too early or too late. Damage to the committed map stays hidden until a recovery. After that, it appears in the first cycle as wrong source tags and as a wrongly rebuilt pool. Every test sequence therefore ends by reading translations and allocations back through the rename port.

// File: rtl/rename_pkg.sv
package rename_pkg;
   // default geometry of the rename map
   localparam int DEF_ARCH_REGS = 32;
   localparam int DEF_PHYS_REGS = 64;

   // identity tag of architectural slot a, used at reset
   function automatic int ident_tag(input int a);
      return a;
   endfunction
endpackage

// File: rtl/rmap_spec_table.sv
module rmap_spec_table #(
   parameter int NUM_ARCH = 32,
   parameter int PW       = 6,
   localparam int AW      = $clog2(NUM_ARCH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          rd_a,
   input  logic [AW-1:0]          rd_b,
   input  logic [AW-1:0]          rd_c,
   output logic [PW-1:0]          tag_a,
   output logic [PW-1:0]          tag_b,
   output logic [PW-1:0]          tag_c,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_idx,
   input  logic [PW-1:0]          wr_tag,
   input  logic                   restore,
   input  logic [NUM_ARCH*PW-1:0] restore_map
);
   logic [PW-1:0] ent_q [NUM_ARCH];

   // reads see the table before this cycle's update
   assign tag_a = ent_q[rd_a];
   assign tag_b = ent_q[rd_b];
   assign tag_c = ent_q[rd_c];

   for (genvar a = 0; a < NUM_ARCH; a++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q[a] <= PW'(rename_pkg::ident_tag(a));
         else if (restore)
            ent_q[a] <= restore_map[a*PW +: PW];
         else if (wr_en && (wr_idx == AW'(a)))
            ent_q[a] <= wr_tag;
      end
   end
endmodule

// File: rtl/rmap_commit_table.sv
module rmap_commit_table #(
   parameter int NUM_ARCH = 32,
   parameter int PW       = 6,
   localparam int AW      = $clog2(NUM_ARCH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd_en,
   input  logic [AW-1:0]          upd_idx,
   input  logic [PW-1:0]          upd_tag,
   output logic [NUM_ARCH*PW-1:0] map_next
);
   logic [NUM_ARCH*PW-1:0] map_q;

   always_comb begin
      map_next = map_q;
      if (upd_en)
         map_next[upd_idx*PW +: PW] = upd_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_ARCH; a++)
            map_q[a*PW +: PW] <= PW'(rename_pkg::ident_tag(a));
      end else begin
         map_q <= map_next;
      end
   end
endmodule

// File: rtl/rmap_free_pool.sv
module rmap_free_pool #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 64,
   localparam int PW      = $clog2(NUM_PHYS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   take,
   input  logic                   give,
   input  logic [PW-1:0]          give_tag,
   input  logic                   rebuild,
   input  logic [NUM_ARCH*PW-1:0] keep_map,
   output logic [PW-1:0]          head_tag,
   output logic                   empty
);
   logic [NUM_PHYS-1:0] free_q;
   logic [NUM_PHYS-1:0] in_use;
   logic [NUM_PHYS-1:0] free_d;

   // lowest-numbered free register wins
   always_comb begin
      head_tag = '0;
      for (int i = NUM_PHYS - 1; i >= 0; i--)
         if (free_q[i]) head_tag = PW'(i);
   end
   assign empty = ~|free_q;

   // registers referenced by the map kept across a rebuild
   always_comb begin
      in_use = '0;
      for (int a = 0; a < NUM_ARCH; a++)
         in_use[keep_map[a*PW +: PW]] = 1'b1;
   end

   always_comb begin
      free_d = free_q;
      if (rebuild) begin
         free_d = ~in_use;
      end else begin
         if (take) free_d[head_tag] = 1'b0;
         if (give) free_d[give_tag] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PHYS; i++)
            free_q[i] <= (i >= NUM_ARCH);
      end else begin
         free_q <= free_d;
      end
   end
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit #(
   parameter int NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
   parameter int NUM_PHYS = rename_pkg::DEF_PHYS_REGS,
   localparam int AW      = $clog2(NUM_ARCH),
   localparam int PW      = $clog2(NUM_PHYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rn_valid,
   input  logic          rn_wen,
   input  logic [AW-1:0] rn_src1,
   input  logic [AW-1:0] rn_src2,
   input  logic [AW-1:0] rn_dst,
   output logic [PW-1:0] rn_src1_tag,
   output logic [PW-1:0] rn_src2_tag,
   output logic [PW-1:0] rn_dst_tag,
   output logic [PW-1:0] rn_old_tag,
   output logic          rn_stall,
   input  logic          cm_valid,
   input  logic [AW-1:0] cm_arch,
   input  logic [PW-1:0] cm_new_tag,
   input  logic [PW-1:0] cm_old_tag,
   input  logic          recover
);
   if (NUM_PHYS <= NUM_ARCH) begin : g_bad_size
      $error("reg_rename_unit: NUM_PHYS must exceed NUM_ARCH");
   end
   if ((1 << AW) != NUM_ARCH || (1 << PW) != NUM_PHYS) begin : g_bad_pow2
      $error("reg_rename_unit: register counts must be powers of two");
   end

   logic                   pool_empty;
   logic                   want_dst;
   logic                   accept;
   logic [NUM_ARCH*PW-1:0] cmt_map;

   assign want_dst = rn_valid && rn_wen && !recover;
   assign accept   = want_dst && !pool_empty;
   assign rn_stall = want_dst && pool_empty;

   rmap_spec_table #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_spec (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_a        (rn_src1),
      .rd_b        (rn_src2),
      .rd_c        (rn_dst),
      .tag_a       (rn_src1_tag),
      .tag_b       (rn_src2_tag),
      .tag_c       (rn_old_tag),
      .wr_en       (accept),
      .wr_idx      (rn_dst),
      .wr_tag      (rn_dst_tag),
      .restore     (recover),
      .restore_map (cmt_map)
   );

   rmap_commit_table #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_cmt (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (cm_valid),
      .upd_idx  (cm_arch),
      .upd_tag  (cm_new_tag),
      .map_next (cmt_map)
   );

   rmap_free_pool #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (accept),
      .give     (cm_valid),
      .give_tag (cm_old_tag),
      .rebuild  (recover),
      .keep_map (cmt_map),
      .head_tag (rn_dst_tag),
      .empty    (pool_empty)
   );
endmodule

// File: rtl/reg_rename_unit_chk.sv
module reg_rename_unit_chk #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 64,
   localparam int AW      = $clog2(NUM_ARCH),
   localparam int PW      = $clog2(NUM_PHYS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rn_valid,
   input logic          rn_wen,
   input logic [AW-1:0] rn_src1,
   input logic [AW-1:0] rn_dst,
   input logic [PW-1:0] rn_src1_tag,
   input logic [PW-1:0] rn_dst_tag,
   input logic [PW-1:0] rn_old_tag,
   input logic          rn_stall,
   input logic          cm_valid,
   input logic          recover
);
   logic took;
   assign took = rn_valid && rn_wen && !recover && !rn_stall;

   // R2
   new_differs_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      took |-> rn_dst_tag != rn_old_tag);

   // R4
   fwd_new_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(took) && rn_src1 == $past(rn_dst)) |-> rn_src1_tag == $past(rn_dst_tag));

   // R7
   stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rn_stall && !cm_valid) && rn_valid && rn_wen && !recover) |-> rn_stall);

   // R8
   commit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && !recover) |=> !rn_stall);

   // R10
   rebuild_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> !rn_stall);

   // R11
   recover_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recover |-> !rn_stall);
endmodule

bind reg_rename_unit reg_rename_unit_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rn_valid    (rn_valid),
   .rn_wen      (rn_wen),
   .rn_src1     (rn_src1),
   .rn_dst      (rn_dst),
   .rn_src1_tag (rn_src1_tag),
   .rn_dst_tag  (rn_dst_tag),
   .rn_old_tag  (rn_old_tag),
   .rn_stall    (rn_stall),
   .cm_valid    (cm_valid),
   .recover     (recover)
);

// File: tb/reg_rename_unit_test.sv
module reg_rename_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rn_valid = 1'b0, rn_wen = 1'b0;
   logic [4:0] rn_src1 = '0, rn_src2 = '0, rn_dst = '0;
   logic [5:0] rn_src1_tag, rn_src2_tag, rn_dst_tag, rn_old_tag;
   logic       rn_stall;
   logic       cm_valid = 1'b0;
   logic [4:0] cm_arch = '0;
   logic [5:0] cm_new_tag = '0, cm_old_tag = '0;
   logic       recover = 1'b0;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   reg_rename_unit uut (.*);

   typedef struct packed {
      logic vld; logic wen;
      logic [4:0] s1; logic [4:0] s2; logic [4:0] d;
      logic [5:0] e1; logic [5:0] e2; logic [5:0] ed; logic [5:0] eo;
   } vec_t;

   // sequence from reset: free pool starts at 32
   localparam vec_t VEC [6] = '{
      '{1'b1, 1'b1, 5'd1, 5'd2, 5'd1, 6'd1,  6'd2,  6'd32, 6'd1},  // R5 R2 R3
      '{1'b1, 1'b1, 5'd1, 5'd2, 5'd2, 6'd32, 6'd2,  6'd33, 6'd2},  // R4
      '{1'b1, 1'b1, 5'd1, 5'd3, 5'd1, 6'd32, 6'd3,  6'd34, 6'd32}, // R3 R5
      '{1'b1, 1'b0, 5'd1, 5'd2, 5'd5, 6'd34, 6'd33, 6'd35, 6'd5},  // R6
      '{1'b0, 1'b1, 5'd1, 5'd0, 5'd1, 6'd34, 6'd0,  6'd35, 6'd34}, // R6
      '{1'b1, 1'b1, 5'd0, 5'd1, 5'd0, 6'd0,  6'd34, 6'd35, 6'd0}   // R2
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle();
      rn_valid = 1'b0; rn_wen = 1'b0; cm_valid = 1'b0; recover = 1'b0;
   endtask

   task automatic req(input logic v, input logic w, input int s1, input int s2, input int d);
      @(negedge clk);
      idle();
      rn_valid = v; rn_wen = w;
      rn_src1 = 5'(s1); rn_src2 = 5'(s2); rn_dst = 5'(d);
      #5;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1 reset mapping and pool
      req(1'b0, 1'b0, 7, 31, 0);
      chk("R1", "src1 identity", rn_src1_tag, 7);
      chk("R1", "src2 identity", rn_src2_tag, 31);
      chk("R1", "first free", rn_dst_tag, 32);
      chk("R7", "no stall idle", rn_stall, 0);

      for (int i = 0; i < 6; i++) begin
         req(VEC[i].vld, VEC[i].wen, VEC[i].s1, VEC[i].s2, VEC[i].d);
         chk("R2-R6 vec", "src1", rn_src1_tag, VEC[i].e1);
         chk("R2-R6 vec", "src2", rn_src2_tag, VEC[i].e2);
         chk("R2 vec", "dst", rn_dst_tag, VEC[i].ed);
         chk("R3 vec", "old", rn_old_tag, VEC[i].eo);
      end

      // R8 commits release superseded registers
      @(negedge clk); idle();
      cm_valid = 1'b1; cm_arch = 5'd1; cm_new_tag = 6'd32; cm_old_tag = 6'd1;
      req(1'b0, 1'b0, 0, 0, 0);
      chk("R8", "freed reg is lowest", rn_dst_tag, 1);
      @(negedge clk); idle();
      cm_valid = 1'b1; cm_arch = 5'd2; cm_new_tag = 6'd33; cm_old_tag = 6'd2;

      // R11 recovery with a rename in the same cycle
      @(negedge clk); idle();
      recover = 1'b1; rn_valid = 1'b1; rn_wen = 1'b1; rn_dst = 5'd4;
      #5;
      chk("R11", "no stall on recovery", rn_stall, 0);
      req(1'b1, 1'b0, 1, 0, 4);
      chk("R11", "dropped rename map", rn_old_tag, 4);
      chk("R9", "restored src1", rn_src1_tag, 32);
      chk("R9", "restored src2", rn_src2_tag, 0);
      chk("R10", "rebuilt head", rn_dst_tag, 1);
      req(1'b1, 1'b0, 2, 0, 0);
      chk("R9", "committed r2", rn_src1_tag, 33);

      // R7 exhaust the pool
      do_reset();
      for (int k = 0; k < 32; k++) begin
         req(1'b1, 1'b1, 5, 0, 5);
         if (k == 0) chk("R3", "first old", rn_old_tag, 5);
         if (k == 31) begin
            chk("R2", "last alloc", rn_dst_tag, 63);
            chk("R3", "chain old", rn_old_tag, 62);
         end
      end
      req(1'b1, 1'b1, 5, 0, 6);
      chk("R7", "stall when empty", rn_stall, 1);
      req(1'b1, 1'b0, 5, 6, 6);
      chk("R7", "stalled write dropped", rn_old_tag, 6);
      chk("R7", "no stall without write", rn_stall, 0);
      chk("R6", "map unchanged", rn_src1_tag, 63);

      // R8 commit frees a register after exhaustion
      @(negedge clk); idle();
      cm_valid = 1'b1; cm_arch = 5'd5; cm_new_tag = 6'd32; cm_old_tag = 6'd5;
      req(1'b1, 1'b1, 0, 0, 9);
      chk("R8", "stall cleared", rn_stall, 0);
      chk("R8", "freed tag", rn_dst_tag, 5);

      // R9 and R10 recovery to committed state
      @(negedge clk); idle();
      recover = 1'b1;
      req(1'b1, 1'b0, 5, 9, 9);
      chk("R9", "restore r5", rn_src1_tag, 32);
      chk("R9", "restore r9", rn_src2_tag, 9);
      chk("R10", "rebuilt head", rn_dst_tag, 5);
      req(1'b1, 1'b1, 0, 0, 7);
      chk("R10", "alloc from rebuilt", rn_dst_tag, 5);
      req(1'b1, 1'b0, 7, 0, 0);
      chk("R10", "unreferenced tag free", rn_dst_tag, 33);
      chk("R4", "new mapping seen", rn_src1_tag, 5);

      @(negedge clk); idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end
endmodule